// File: doc/BRIEF.md
# DAC Static Linearity Sweep Checker

This block measures the static linearity of an N-bit digital-to-analog converter. A pulse on `start` begins a sweep. The block presents each DAC code in turn, starting at zero and counting up to the all-ones code. After each code it waits a programmable settle time. It then takes one sample from a readback ADC that has M bits, where M is at least N+2. The block compares that sample with the ideal level for the code and reports, for every code:

- the signed error, in ADC counts;
- a flag that shows whether the error reaches half a DAC LSB;
- the step in error from the previous code, which is the DNL.

No best-fit line is computed. The ideal level is the code shifted up by M−N bits, so one DAC LSB equals 2^(M−N) ADC counts. The error bits below the half-LSB position are kept, so errors smaller than half an LSB can still be resolved.

During the sweep the block keeps running summaries: the largest error magnitude and the code where it occurred, the largest DNL magnitude and its code, and a sticky flag that records any INL violation. `done` pulses once when the all-ones code has been measured.

Top module: `lincheck_sweep`

## Requirements
- R1: When `start` is high while the block is idle, the next cycle shows `busy`=1, `dac_code`=0 and `dac_strobe`=1.
- R2: `dac_strobe` is high for exactly one cycle per code. Each strobe after the first carries a code one higher than the previous result code. The last strobe carries the all-ones code.
- R3: `adc_valid` is ignored in the cycle of `dac_strobe` and in the `settle_cycles` cycles that follow. It is accepted in the first cycle after those. The result appears one cycle after acceptance, and the next code's strobe appears in that same cycle.
- R4: `res_err` is `adc_sample − dac_code·2^(M−N)`, given as an (M+1)-bit two's-complement value with every low bit kept.
- R5: `res_inl` is 1 exactly when |`res_err`| ≥ 2^(M−N−1), which is half a DAC LSB.
- R6: `res_dnl` is the current `res_err` minus the previous code's `res_err`, as (M+2)-bit two's complement, with `res_dnl_valid`=1. For code 0, `res_dnl_valid`=0 and `res_dnl`=0.
- R7: `worst_err_mag` and `worst_err_code` hold the largest |error| seen so far in the sweep and its code. Only a strictly larger value replaces them, so on a tie the earliest code is kept.
- R8: `worst_dnl_mag` and `worst_dnl_code` track the largest |DNL| over codes 1 and above, under the same tie rule as R7.
- R9: `inl_any` becomes 1 after any result with `res_inl`=1 and stays 1 until the next sweep starts.
- R10: `done` is high for one cycle, in the cycle of the all-ones result. `busy` is 0 from that cycle on.
- R11: An accepted `start` clears `inl_any`, both worst magnitudes and both worst codes to 0.
- R12: A `start` that arrives while `busy`=1 has no effect: the code sequence continues and the summaries are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sweep (used only when idle) |
| settle_cycles | input | SW | Extra wait cycles after each strobe |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse at the end of the sweep |
| dac_code | output | N | Code applied to the DAC |
| dac_strobe | output | 1 | A new code is presented |
| adc_sample | input | M | Readback sample |
| adc_valid | input | 1 | Readback sample is valid |
| res_valid | output | 1 | Per-code result is valid |
| res_code | output | N | Code of the current result |
| res_err | output | M+1 | Signed error in ADC counts |
| res_inl | output | 1 | Error magnitude is at least half an LSB |
| res_dnl | output | M+2 | Signed error step from the previous code |
| res_dnl_valid | output | 1 | `res_dnl` is meaningful |
| worst_err_mag | output | M+1 | Largest error magnitude |
| worst_err_code | output | N | Code of the largest error |
| worst_dnl_mag | output | M+2 | Largest DNL magnitude |
| worst_dnl_code | output | N | Code of the largest DNL |
| inl_any | output | 1 | Sticky INL violation flag |

## Verification
The gap assertion assumes that `settle_cycles` is held constant for a whole sweep. The design loads it again at every code, so a change in the middle of a sweep would break the measured spacing. The bench changes it only between sweeps.

The properties also assume that `adc_sample` always fits in M bits and that a sample is only meaningful while `adc_valid` is high. The bench follows this: it drives a deliberately wrong sample during the settle window and the correct one only once the window has closed. Because of this, any early acceptance shows up as a wrong error value.

// File: rtl/lincheck_pkg.sv
package lincheck_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WAIT
    } sweep_state_e;
endpackage

// File: rtl/lincheck_metric.sv
// Per-code arithmetic: error against the ideal level, half-LSB flag, error step.
module lincheck_metric #(
    parameter int N = 4,
    parameter int M = 7
) (
    input  logic [M-1:0]        adc,
    input  logic [N-1:0]        code,
    input  logic signed [M:0]   prev_err,
    output logic signed [M:0]   err,
    output logic [M:0]          err_mag,
    output logic                inl_flag,
    output logic signed [M+1:0] dnl,
    output logic [M+1:0]        dnl_mag
);
    localparam int D = M - N;

    logic [M:0] ideal;

    always_comb begin
        ideal    = {1'b0, code, {D{1'b0}}};
        err      = $signed({1'b0, adc}) - $signed(ideal);
        err_mag  = err[M] ? $unsigned(-err) : $unsigned(err);
        // any set bit at or above the half-LSB position (R5)
        inl_flag = |err_mag[M:D-1];
        dnl      = $signed({err[M], err}) - $signed({prev_err[M], prev_err});
        dnl_mag  = dnl[M+1] ? $unsigned(-dnl) : $unsigned(dnl);
    end
endmodule

// File: rtl/lincheck_peak.sv
// Running maximum with the index where it first occurred.
module lincheck_peak #(
    parameter int W  = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [W-1:0]  mag,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  peak,
    output logic [IW-1:0] peak_idx
);
    logic [W-1:0]  peak_d, peak_q;
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        peak_d = peak_q;
        idx_d  = idx_q;
        if (clr) begin
            peak_d = '0;
            idx_d  = '0;
        end else if (upd && (mag > peak_q)) begin
            peak_d = mag;
            idx_d  = idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
            idx_q  <= '0;
        end else begin
            peak_q <= peak_d;
            idx_q  <= idx_d;
        end
    end

    assign peak     = peak_q;
    assign peak_idx = idx_q;

    assert_peak_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> peak_q >= $past(peak_q));
endmodule

// File: rtl/lincheck_sweep.sv
module lincheck_sweep #(
    parameter int N  = 4,
    parameter int M  = 7,
    parameter int SW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SW-1:0]       settle_cycles,
    output logic                busy,
    output logic                done,
    output logic [N-1:0]        dac_code,
    output logic                dac_strobe,
    input  logic [M-1:0]        adc_sample,
    input  logic                adc_valid,
    output logic                res_valid,
    output logic [N-1:0]        res_code,
    output logic signed [M:0]   res_err,
    output logic                res_inl,
    output logic signed [M+1:0] res_dnl,
    output logic                res_dnl_valid,
    output logic [M:0]          worst_err_mag,
    output logic [N-1:0]        worst_err_code,
    output logic [M+1:0]        worst_dnl_mag,
    output logic [N-1:0]        worst_dnl_code,
    output logic                inl_any
);
    import lincheck_pkg::*;

    localparam logic [N-1:0] LAST_CODE = '1;
    localparam int           GW        = SW + 2;

    typedef struct packed {
        sweep_state_e      state;
        logic [N-1:0]      code;
        logic [SW-1:0]     cnt;
        logic              strobe;
        logic              done;
        logic signed [M:0] prev_err;
        logic              res_valid;
        logic [N-1:0]      res_code;
        logic signed [M:0] res_err;
        logic              res_inl;
        logic signed [M+1:0] res_dnl;
        logic              res_dnl_valid;
        logic              inl_any;
    } sweep_t;

    sweep_t st_d, st_q;

    logic signed [M:0]   err;
    logic [M:0]          err_mag;
    logic                inl_flag;
    logic signed [M+1:0] dnl;
    logic [M+1:0]        dnl_mag;
    logic                clr, take;

    lincheck_metric #(.N(N), .M(M)) u_metric (
        .adc      (adc_sample),
        .code     (st_q.code),
        .prev_err (st_q.prev_err),
        .err      (err),
        .err_mag  (err_mag),
        .inl_flag (inl_flag),
        .dnl      (dnl),
        .dnl_mag  (dnl_mag)
    );

    lincheck_peak #(.W(M+1), .IW(N)) u_peak_err (
        .clk (clk), .rst_n (rst_n), .clr (clr), .upd (take),
        .mag (err_mag), .idx (st_q.code),
        .peak (worst_err_mag), .peak_idx (worst_err_code)
    );

    lincheck_peak #(.W(M+2), .IW(N)) u_peak_dnl (
        .clk (clk), .rst_n (rst_n), .clr (clr), .upd (take && (st_q.code != '0)),
        .mag (dnl_mag), .idx (st_q.code),
        .peak (worst_dnl_mag), .peak_idx (worst_dnl_code)
    );

    always_comb begin
        st_d           = st_q;
        st_d.strobe    = 1'b0;
        st_d.done      = 1'b0;
        st_d.res_valid = 1'b0;
        clr            = 1'b0;
        take           = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state   = ST_SETTLE;
                    st_d.code    = '0;
                    st_d.cnt     = settle_cycles;
                    st_d.strobe  = 1'b1;
                    st_d.inl_any = 1'b0;
                    clr          = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (st_q.cnt == '0) st_d.state = ST_WAIT;
                else                st_d.cnt   = st_q.cnt - 1'b1;
            end
            ST_WAIT: begin
                if (adc_valid) begin
                    take               = 1'b1;
                    st_d.res_valid     = 1'b1;
                    st_d.res_code      = st_q.code;
                    st_d.res_err       = err;
                    st_d.res_inl       = inl_flag;
                    st_d.res_dnl_valid = (st_q.code != '0);
                    st_d.res_dnl       = (st_q.code != '0) ? dnl : '0;
                    st_d.prev_err      = err;
                    st_d.inl_any       = st_q.inl_any | inl_flag;
                    if (st_q.code == LAST_CODE) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.state  = ST_SETTLE;
                        st_d.code   = st_q.code + 1'b1;
                        st_d.cnt    = settle_cycles;
                        st_d.strobe = 1'b1;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy          = (st_q.state != ST_IDLE);
    assign done          = st_q.done;
    assign dac_code      = st_q.code;
    assign dac_strobe    = st_q.strobe;
    assign res_valid     = st_q.res_valid;
    assign res_code      = st_q.res_code;
    assign res_err       = st_q.res_err;
    assign res_inl       = st_q.res_inl;
    assign res_dnl       = st_q.res_dnl;
    assign res_dnl_valid = st_q.res_dnl_valid;
    assign inl_any       = st_q.inl_any;

    // ---------------- checks ----------------
    assert_width_margin_R4: assert final (M >= N + 2);

    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             gap_q <= '0;
        else if (dac_strobe)    gap_q <= GW'(1);
        else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
    end

    assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> gap_q >= ({2'b00, settle_cycles} + GW'(2)));

    assert_code_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_strobe && dac_code != '0) |-> (res_valid && dac_code == res_code + 1'b1));

    assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |-> busy);

    assert_dnl_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_dnl_valid == (res_code != '0)));

    assert_inl_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_inl) |-> inl_any);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_valid && res_code == LAST_CODE && !busy));

    assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !(dac_strobe && dac_code == '0));
endmodule

// File: tb/lincheck_sweep_tb.sv
`timescale 1ns/1ps
module lincheck_sweep_tb;
    localparam int N  = 4;
    localparam int M  = 7;
    localparam int SW = 8;
    localparam int CODES = 1 << N;
    localparam int STEP  = 1 << (M - N);
    localparam int HALF  = STEP / 2;

    // per-code error pattern in ADC counts (first sweep)
    localparam int ERR_TAB [CODES] = '{0, 1, -1, 3, 4, -4, 2, 0, -3, 5, -7, 6, 1, 0, -7, -5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [SW-1:0] settle_cycles = '0;
    logic [M-1:0] adc_sample = '0;
    logic adc_valid = 1'b0;
    logic busy, done, dac_strobe, res_valid, res_inl, res_dnl_valid, inl_any;
    logic [N-1:0] dac_code, res_code, worst_err_code, worst_dnl_code;
    logic signed [M:0] res_err;
    logic signed [M+1:0] res_dnl;
    logic [M:0] worst_err_mag;
    logic [M+1:0] worst_dnl_mag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lincheck_sweep #(.N(N), .M(M), .SW(SW)) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .settle_cycles (settle_cycles),
        .busy (busy), .done (done), .dac_code (dac_code), .dac_strobe (dac_strobe),
        .adc_sample (adc_sample), .adc_valid (adc_valid),
        .res_valid (res_valid), .res_code (res_code), .res_err (res_err),
        .res_inl (res_inl), .res_dnl (res_dnl), .res_dnl_valid (res_dnl_valid),
        .worst_err_mag (worst_err_mag), .worst_err_code (worst_err_code),
        .worst_dnl_mag (worst_dnl_mag), .worst_dnl_code (worst_dnl_code),
        .inl_any (inl_any)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // mode 0: ERR_TAB; mode 1: alternating 0/+1 (all below half LSB)
    function automatic int err_of(input int mode, input int k);
        return (mode == 0) ? ERR_TAB[k] : (k % 2);
    endfunction

    task automatic run_sweep(input int settle, input int mode, input int poke_code);
        int prev = 0;
        int w_err = 0, w_err_c = 0, w_dnl = 0, w_dnl_c = 0;
        bit any = 0;
        settle_cycles = SW'(settle);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R1 busy", int'(busy), 1);
        chk("R11 worst_err cleared", int'(worst_err_mag), 0);
        chk("R11 inl_any cleared", int'(inl_any), 0);
        for (int k = 0; k < CODES; k++) begin
            int e, d, waits;
            e = err_of(mode, k);
            d = e - prev;
            chk($sformatf("R2 strobe k=%0d", k), int'(dac_strobe), 1);
            chk($sformatf("R2 code k=%0d", k), int'(dac_code), k);
            // wrong sample throughout the settle window: must be ignored (R3)
            adc_sample = M'(k * STEP + e + 3);
            adc_valid  = 1'b1;
            if (k == poke_code) start = 1'b1;
            for (int i = 0; i <= settle; i++) begin
                @(negedge clk);
                start = 1'b0;
                if (i == 0 && settle > 0)
                    chk("R2 strobe single", int'(dac_strobe), 0);
            end
            adc_sample = M'(k * STEP + e);
            waits = 0;
            do begin
                @(negedge clk);
                waits++;
            end while (!res_valid && waits < 50);
            adc_valid = 1'b0;
            chk("R3 accept first cycle", waits, 1);
            chk($sformatf("R3 res_code k=%0d", k), int'(res_code), k);
            chk($sformatf("R4 err k=%0d", k), int'(res_err), e);
            chk($sformatf("R5 inl k=%0d", k), int'(res_inl), int'(iabs(e) >= HALF));
            chk($sformatf("R6 dnl_valid k=%0d", k), int'(res_dnl_valid), int'(k != 0));
            chk($sformatf("R6 dnl k=%0d", k), int'(res_dnl), (k == 0) ? 0 : d);
            if (iabs(e) > w_err) begin w_err = iabs(e); w_err_c = k; end
            if (k != 0 && iabs(d) > w_dnl) begin w_dnl = iabs(d); w_dnl_c = k; end
            any |= (iabs(e) >= HALF);
            chk("R7 worst_err_mag", int'(worst_err_mag), w_err);
            chk("R7 worst_err_code", int'(worst_err_code), w_err_c);
            chk("R8 worst_dnl_mag", int'(worst_dnl_mag), w_dnl);
            chk("R8 worst_dnl_code", int'(worst_dnl_code), w_dnl_c);
            chk("R9 inl_any", int'(inl_any), int'(any));
            chk("R10 done timing", int'(done), int'(k == CODES - 1));
            if (k == CODES - 1) chk("R10 busy drops", int'(busy), 0);
            prev = e;
        end
        @(negedge clk);
        chk("R10 done one cycle", int'(done), 0);
        chk("R2 no strobe after last", int'(dac_strobe), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("reset busy", int'(busy), 0);
        chk("reset done", int'(done), 0);
        chk("reset strobe", int'(dac_strobe), 0);
        chk("reset res_valid", int'(res_valid), 0);
        chk("reset inl_any", int'(inl_any), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // table sweep with settle 3 and a start pulse mid-sweep (R12)
        run_sweep(3, 0, 5);
        chk("R12 summary kept after ignored start", int'(worst_err_code), 10);
        repeat (2) @(negedge clk);
        // sub-half-LSB sweep, settle 0: summaries must start from zero (R11)
        run_sweep(0, 1, -1);
        chk("R5 no violation in small sweep", int'(inl_any), 0);
        // idle start-free period: nothing moves
        repeat (4) @(negedge clk);
        chk("R1 idle stays idle", int'(busy), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule